// File: doc/BRIEF.md
# TDM Time Slot Interchange Core

This block is a non-blocking time slot switch for time-division multiplexed traffic. Each of `STREAMS` streams carries 32 byte-wide channels per 125 µs frame. One clock cycle is one channel slot, and in that slot every stream presents one parallel byte. A frame pulse restarts the channel counter. The counter addresses a double-buffered data memory for writes and a connection memory for reads.

The connection memory holds one 16-bit word per output stream and channel. That word says how the output byte is formed. It can route any input stream and channel to the output. It can also send a literal byte that the host wrote. The word further selects constant or variable delay, enables or disables the output for that slot, and can loop the transmitted byte back into the matching input slot.

Two master controls disable every output together: the `out_en_i` pin and an active bit in a host control register. A small synchronous host port writes the connection words and the control register, and reads them back.

Top module: `tsi_core`

## Requirements
- R1: A cycle with `frame_i` high is channel slot 0. Otherwise each cycle is the next slot, and the count wraps from 31 back to 0. The data memory page alternates at every slot 0.
- R2: In each slot, the byte of every input stream is stored at (current page, stream, slot). The write happens in that slot's cycle.
- R3: Connection mode (word bit 14 = 0) sends the stored byte from source channel bits [4:0] and source stream bits [9:5]. It appears on `tx_data_o` in the cycle after the slot. Several outputs may name the same source.
- R4: Processor mode (bit 14 = 1) sends word bits [7:0] in that channel every frame until the word is rewritten.
- R5: Constant delay (bit 13 = 1) always reads the byte stored in the previous frame.
- R6: Variable delay (bit 13 = 0) reads the current frame's byte when the source channel number is below the current slot. Otherwise it reads the previous frame's byte.
- R7: With bit 12 = 0, that slot's `tx_oe_o` bit is low and its `tx_data_o` byte is 0x00.
- R8: If `out_en_i` is low, or the control register active bit (bit 0) is 0, then every `tx_oe_o` bit is low and every output byte is 0x00.
- R9: With bit 15 = 1, the byte sent on output stream n in slot m is stored as input stream n slot m, in place of `rx_data_i`.
- R10: A connection-mode source is out of range when the value in bits [11:5] is `STREAMS` or more. Such a source sends 0x00.
- R11: Reset clears the counters, the control register and both memories. All outputs stay disabled until reset is released.
- R12: The host address is {select, stream, channel}. A write with `host_we_i` takes effect at the clock edge. `host_rdata_o` shows the addressed connection word (select = 0), or the control register (select = 1), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one channel slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame start marker, slot 0 |
| rx_data_i | input | STREAMS*8 | Input byte of every stream, stream n at [8n+7:8n] |
| out_en_i | input | 1 | Master output enable |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | log2(STREAMS)+6 | Host address {select, stream, channel} |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data |
| tx_data_o | output | STREAMS*8 | Output byte of every stream |
| tx_oe_o | output | STREAMS | Per-stream output enable for the current slot |

## Verification
The hardest case to reach is the variable-delay page choice when loopback feeds a slot that another output reads in the same frame. To hit it, the source channel must sit on either side of the reading slot, and the looped byte must differ from the pin byte. The stimulus fills every connection word from a hashed pattern that mixes all modes, shared sources, out-of-range streams and loopback. It then changes the pattern and forces an early frame pulse mid-frame. A behavioural model of both pages predicts every output byte on every cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CH_W     = 5;
  localparam int CHANNELS = 32;

  typedef struct packed {
    logic       lpbk;
    logic       proc;
    logic       cdly;
    logic       oe;
    logic [1:0] rsvd;
    logic [4:0] src_st;
    logic [4:0] src_ch;
  } conn_word_t;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  output logic [CH_W-1:0] cur_ch_o,
  output logic            cur_page_o,
  output logic [CH_W-1:0] ch_q_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(CHANNELS - 1);

  logic [CH_W-1:0] ch_q;
  logic            par_q;

  always_comb begin
    if (frame_i || ch_q == LAST) cur_ch_o = '0;
    else                         cur_ch_o = ch_q + 1'b1;
    cur_page_o = (cur_ch_o == '0) ? ~par_q : par_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q  <= LAST;
      par_q <= 1'b0;
    end else begin
      ch_q  <= cur_ch_o;
      par_q <= cur_page_o;
    end
  end

  assign ch_q_o = ch_q;
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter  int STREAMS = 4,
  localparam int SW      = $clog2(STREAMS),
  localparam int IW      = SW + CH_W,
  localparam int DEPTH   = STREAMS * CHANNELS,
  localparam int AW      = IW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [15:0]      host_wdata_i,
  output logic [15:0]      host_rdata_o,
  input  logic [CH_W-1:0]  cur_ch_i,
  output conn_word_t       rd_word_o [STREAMS],
  output logic             active_o
);
  conn_word_t mem [DEPTH];
  logic       active_q;

  wire           sel_ctrl = host_addr_i[AW-1];
  wire [IW-1:0]  h_idx    = host_addr_i[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem      <= '{default: '0};
      active_q <= 1'b0;
    end else if (host_we_i) begin
      if (sel_ctrl) active_q   <= host_wdata_i[0];
      else          mem[h_idx] <= conn_word_t'(host_wdata_i);
    end
  end

  assign host_rdata_o = sel_ctrl ? {15'b0, active_q} : 16'(mem[h_idx]);
  assign active_o     = active_q;

  for (genvar g = 0; g < STREAMS; g++) begin : g_rd
    assign rd_word_o[g] = mem[{SW'(g), cur_ch_i}];
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter  int STREAMS = 4,
  localparam int SW      = $clog2(STREAMS),
  localparam int IW      = 1 + SW + CH_W,
  localparam int DEPTH   = 2 * STREAMS * CHANNELS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_page_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [7:0]      wr_data_i [STREAMS],
  input  logic            rd_page_i [STREAMS],
  input  logic [SW-1:0]   rd_st_i   [STREAMS],
  input  logic [CH_W-1:0] rd_ch_i   [STREAMS],
  output logic [7:0]      rd_data_o [STREAMS]
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem <= '{default: '0};
    end else begin
      for (int s = 0; s < STREAMS; s++)
        mem[IW'({wr_page_i, SW'(s), wr_ch_i})] <= wr_data_i[s];
    end
  end

  for (genvar g = 0; g < STREAMS; g++) begin : g_rd
    assign rd_data_o[g] = mem[{rd_page_i[g], rd_st_i[g], rd_ch_i[g]}];
  end
endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter  int STREAMS = 4,
  localparam int SW      = $clog2(STREAMS),
  localparam int AW      = SW + CH_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic [STREAMS*8-1:0] rx_data_i,
  input  logic               out_en_i,
  input  logic               host_we_i,
  input  logic [AW-1:0]      host_addr_i,
  input  logic [15:0]        host_wdata_i,
  output logic [15:0]        host_rdata_o,
  output logic [STREAMS*8-1:0] tx_data_o,
  output logic [STREAMS-1:0] tx_oe_o
);
  logic [CH_W-1:0] cur_ch, ch_q;
  logic            cur_page;
  logic            active;

  conn_word_t      cw_rd    [STREAMS];
  logic [7:0]      dm_rd    [STREAMS];
  logic [7:0]      out_byte [STREAMS];
  logic [7:0]      wr_byte  [STREAMS];
  logic            rd_page  [STREAMS];
  logic [SW-1:0]   rd_st    [STREAMS];
  logic [CH_W-1:0] rd_ch    [STREAMS];
  logic [7:0]      tx_q     [STREAMS];
  logic [STREAMS-1:0] oe_q;

  tsi_timing i_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .cur_ch_o   (cur_ch),
    .cur_page_o (cur_page),
    .ch_q_o     (ch_q)
  );

  tsi_conn_mem #(.STREAMS(STREAMS)) i_conn_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .cur_ch_i     (cur_ch),
    .rd_word_o    (cw_rd),
    .active_o     (active)
  );

  tsi_data_mem #(.STREAMS(STREAMS)) i_data_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_page_i (cur_page),
    .wr_ch_i   (cur_ch),
    .wr_data_i (wr_byte),
    .rd_page_i (rd_page),
    .rd_st_i   (rd_st),
    .rd_ch_i   (rd_ch),
    .rd_data_o (dm_rd)
  );

  for (genvar g = 0; g < STREAMS; g++) begin : g_path
    logic in_rng;
    assign rd_st[g]   = cw_rd[g].src_st[SW-1:0];
    assign rd_ch[g]   = cw_rd[g].src_ch;
    // variable delay uses this frame's page only for already-stored slots
    assign rd_page[g] = (!cw_rd[g].cdly && (cw_rd[g].src_ch < cur_ch)) ? cur_page : ~cur_page;
    assign in_rng     = {cw_rd[g].rsvd, cw_rd[g].src_st} < 7'(STREAMS);
    assign out_byte[g] = cw_rd[g].proc ? {cw_rd[g].src_st[2:0], cw_rd[g].src_ch}
                       : (in_rng ? dm_rd[g] : 8'h00);
    assign wr_byte[g]  = cw_rd[g].lpbk ? out_byte[g] : rx_data_i[g*8 +: 8];
    assign tx_oe_o[g]  = oe_q[g] & out_en_i & active;
    assign tx_data_o[g*8 +: 8] = tx_oe_o[g] ? tx_q[g] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '{default: '0};
      oe_q <= '0;
    end else begin
      for (int s = 0; s < STREAMS; s++) begin
        tx_q[s] <= out_byte[s];
        oe_q[s] <= cw_rd[s].oe;
      end
    end
  end
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int STREAMS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_i,
  input logic               out_en_i,
  input logic               active_i,
  input logic [4:0]         ch_q_i,
  input logic [15:0]        cw0_i,
  input logic [7:0]         tx0_q_i,
  input logic [STREAMS-1:0] tx_oe_i
);
  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (ch_q_i == 5'd0)); // R1

  AST_CH_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && ch_q_i != 5'd31) |=> (ch_q_i == $past(ch_q_i) + 5'd1)); // R1

  AST_PROC_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw0_i[14] |=> (tx0_q_i == $past(cw0_i[7:0]))); // R4

  AST_CHAN_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw0_i[12] |=> !tx_oe_i[0]); // R7

  AST_MASTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_en_i || !active_i) |-> (tx_oe_i == '0)); // R8
endmodule

bind tsi_core tsi_core_chk #(.STREAMS(STREAMS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_i  (frame_i),
  .out_en_i (out_en_i),
  .active_i (active),
  .ch_q_i   (ch_q),
  .cw0_i    (cw_rd[0]),
  .tx0_q_i  (tx_q[0]),
  .tx_oe_i  (tx_oe_o)
);

// File: tb/test_tsi_core.sv
module test_tsi_core;
  localparam int S  = 4;
  localparam int AW = $clog2(S) + 6;

  logic clk = 1'b0;
  logic rst_ni;
  logic frame_i;
  logic [S*8-1:0] rx_data_i;
  logic out_en_i;
  logic host_we_i;
  logic [AW-1:0] host_addr_i;
  logic [15:0] host_wdata_i;
  logic [15:0] host_rdata_o;
  logic [S*8-1:0] tx_data_o;
  logic [S-1:0] tx_oe_o;

  always #5 clk = ~clk;

  tsi_core #(.STREAMS(S)) i_tsi_core (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .rx_data_i(rx_data_i),
    .out_en_i(out_en_i), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o)
  );

  int checks = 0;
  int errors = 0;
  int dm [2][S][32];
  int cm [S*32];
  int m_ch, m_par, m_active, cyc;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (slot %0d)", tag, act, exp, m_ch);
    end
  endtask

  function automatic string tag_of(input int w);
    int st = (w >> 5) & 127;
    if (((w >> 12) & 1) == 0) return "R7";
    if (((w >> 14) & 1) == 1) return "R4";
    if (st >= S)              return "R10";
    if (((w >> 15) & 1) == 1) return "R9";
    if (((w >> 13) & 1) == 1) return "R3 R5";
    return "R3 R6 R2";
  endfunction

  task automatic step(input bit early);
    int cur, par, w, st, sc, pg;
    int ob [S];
    int eo [S];
    string tg [S];
    bit fr = early || (m_ch == 31);
    frame_i = fr;
    for (int n = 0; n < S; n++) rx_data_i[n*8 +: 8] = 8'((cyc * 37 + n * 101 + 13) & 255);
    cur = fr ? 0 : m_ch + 1;
    par = (cur == 0) ? 1 - m_par : m_par;
    for (int n = 0; n < S; n++) begin
      w  = cm[n*32 + cur];
      st = (w >> 5) & 127;
      sc = w & 31;
      if (((w >> 14) & 1) == 1)  ob[n] = w & 255;
      else if (st >= S)          ob[n] = 0;
      else begin
        pg = (((w >> 13) & 1) == 0 && sc < cur) ? par : 1 - par;
        ob[n] = dm[pg][st][sc];
      end
      eo[n] = (w >> 12) & 1;
      tg[n] = tag_of(w);
    end
    for (int n = 0; n < S; n++)
      dm[par][n][cur] = (((cm[n*32 + cur] >> 15) & 1) == 1) ? ob[n] : int'(rx_data_i[n*8 +: 8]);
    if (host_we_i) begin
      if (host_addr_i[AW-1]) m_active = int'(host_wdata_i[0]);
      else cm[int'(host_addr_i[AW-2:0])] = int'(host_wdata_i);
    end
    m_ch = cur; m_par = par; cyc++;
    @(posedge clk);
    @(negedge clk);
    for (int n = 0; n < S; n++) begin
      int e_oe = (eo[n] == 1 && m_active == 1 && out_en_i) ? 1 : 0;
      string t = (m_active == 1 && out_en_i) ? tg[n] : "R8";
      chk(t, int'(tx_oe_o[n]), e_oe);
      chk(t, int'(tx_data_o[n*8 +: 8]), e_oe == 1 ? ob[n] : 0);
    end
  endtask

  task automatic hwr(input int a, input int d);
    host_we_i = 1'b1; host_addr_i = AW'(a); host_wdata_i = 16'(d);
    step(1'b0);
    host_we_i = 1'b0;
  endtask

  function automatic int cfg_word(input int n, input int c, input int seed);
    int k  = (n * 7 + c * 3 + seed) % 8;
    int sc = (c * 5 + n * 11 + seed) % 32;
    int ss = (n + c * 3 + seed) % S;
    int w  = (ss << 5) | sc;
    case (k)
      0: w |= (1 << 12);
      1: w |= (1 << 12) | (1 << 13);
      2: w = (1 << 14) | (1 << 12) | ((c * 29 + n * 7 + seed) & 255);
      3: w = w;
      4: w |= (1 << 12) | (1 << 15);
      5: w |= (1 << 12) | (1 << 15) | (1 << 13);
      6: w = (1 << 12) | ((S + c % 3) << 5) | sc | ((c % 2) << 10);
      default: w = (1 << 12) | (1 << 5) | 3;
    endcase
    return w;
  endfunction

  task automatic load_cfg(input int seed);
    for (int n = 0; n < S; n++)
      for (int c = 0; c < 32; c++) hwr(n * 32 + c, cfg_word(n, c, seed));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; frame_i = 1'b0; rx_data_i = '0; out_en_i = 1'b0;
    host_we_i = 1'b0; host_addr_i = '0; host_wdata_i = '0;
    m_ch = 31; m_par = 0; m_active = 0; cyc = 0;
    for (int i = 0; i < S * 32; i++) cm[i] = 0;
    for (int p = 0; p < 2; p++)
      for (int n = 0; n < S; n++)
        for (int c = 0; c < 32; c++) dm[p][n][c] = 0;
    repeat (3) @(negedge clk);
    chk("R11", int'(tx_oe_o), 0);
    host_addr_i = AW'(1 << (AW - 1));
    #1 chk("R11", int'(host_rdata_o), 0);
    host_addr_i = '0;
    #1 chk("R11", int'(host_rdata_o), 0);
    rst_ni = 1'b1;
    out_en_i = 1'b1;
    hwr(1 << (AW - 1), 1);
    load_cfg(0);
    // host readback
    for (int i = 0; i < 3; i++) begin
      host_addr_i = AW'(i * 37);
      #1 chk("R12", int'(host_rdata_o), cfg_word((i * 37) / 32, (i * 37) % 32, 0));
    end
    host_addr_i = AW'(1 << (AW - 1));
    #1 chk("R12", int'(host_rdata_o), 1);
    repeat (128) step(1'b0);
    load_cfg(5);
    repeat (128) step(1'b0);
    out_en_i = 1'b0;
    repeat (32) step(1'b0);
    out_en_i = 1'b1;
    hwr(1 << (AW - 1), 0);
    repeat (32) step(1'b0);
    hwr(1 << (AW - 1), 1);
    // early frame pulse mid-frame
    while (m_ch != 10) step(1'b0);
    step(1'b1);
    repeat (80) step(1'b0);
    load_cfg(3);
    while (m_ch != 20) step(1'b0);
    step(1'b1);
    repeat (96) step(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule